// File: doc/BRIEF.md
# Secure SRAM Region and Master Access Guard

This block is a small register-mapped security controller that sits on a 32-bit APB-style slave port. It holds two kinds of state. The first is a region-size register. It marks a bottom slice of an on-chip SRAM as secure, counted in 4 KB pages. The second is three 8-bit protection groups, which are driven out as a 24-bit vector of non-secure enable lines toward masters or slaves elsewhere in the chip.

Protection bits are never written directly. Each group has one address that sets bits and another that clears bits, and a written 0 leaves a bit untouched. Each group's current value can be read back at its own status address.

A combinational region checker runs alongside the register file. It takes an SRAM byte offset and the non-secure flag of an access, and it raises a violation when a non-secure access falls inside the secure slice. A register write that arrives from the non-secure world is dropped and answered with an error response.

Top module: `sram_guard`

## Requirements
- R1: A write to offset 0x000 stores bits [9:0] of the write data as the region size; higher bits are discarded. A read of 0x000 returns the size in bits [9:0] and zero above.
- R2: Writing to a set address (group 0: 0x804, group 1: 0x810, group 2: 0x81C) sets every protection bit whose write-data bit [7:0] is 1. Bits written as 0 and data bits above bit 7 have no effect.
- R3: Writing to a clear address (group 0: 0x808, group 1: 0x814, group 2: 0x820) clears every protection bit whose write-data bit [7:0] is 1. Other bits keep their state.
- R4: A read of a status address (group 0: 0x800, group 1: 0x80C, group 2: 0x818) returns that group's 8 bits in [7:0]. A read of any set or clear address returns zero.
- R5: After reset the size register holds 0x200, all protection bits are 0, and `ns_enable` is all zero.
- R6: `ns_enable` bit 8*g+i equals bit i of group g. It changes on the clock edge that ends the write access phase and holds its value in every cycle without a group write.
- R7: With a size S between 1 and 0x1FF, a non-secure check is flagged when the offset is below S*4096 and is not flagged at or above it. With S = 0, no check is flagged.
- R8: With a size of 0x200 or more, every non-secure check is flagged, whatever the offset.
- R9: A check with `chk_ns` low is never flagged.
- R10: A write access phase with `pns` high changes no register and drives `pslverr` high. Secure writes and all reads leave `pslverr` low.
- R11: `pready` is always high, so every transfer completes in its first access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| pns | input | 1 | Bus access originates in the non-secure world |
| paddr | input | 12 | Byte offset within the controller window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer ready, tied high |
| pslverr | output | 1 | Error response for a non-secure write |
| ns_enable | output | 24 | Protection bits of the three groups, group 0 in the low byte |
| chk_offset | input | 22 | SRAM byte offset of the access being checked |
| chk_ns | input | 1 | Checked access is non-secure |
| chk_violation | output | 1 | Checked access hits the secure region |

## Verification
The bench probes the page edges of the region: the last byte below S*4096 and the first byte at it, the largest ordinary size 0x1FF, size 0, and the saturating codes 0x200 and 0x3FF. A compare that was off by one page, or that used a plain compare for a saturating code, would flag the wrong side of an edge. It also writes set data that has junk in the upper bits, zero masks, and size data with bits above bit 9. A design that did not mask these would corrupt neighbouring state or read back an oversized value. Finally, a non-secure write is issued to a set address. A design that forgot to block it would change the status read-back or fail to return the error.

// File: rtl/sram_guard_pkg.sv
package sram_guard_pkg;
  // Address map of the controller window (byte offsets).
  localparam int unsigned SIZE_OFF   = 'h000;
  localparam int unsigned GRP_BASE   = 'h800;
  localparam int unsigned GRP_STRIDE = 12;
  localparam int unsigned SET_DELTA  = 4;
  localparam int unsigned CLR_DELTA  = 8;

  // Byte offset of the status word of group g.
  function automatic int unsigned grp_status_off(input int unsigned g);
    return GRP_BASE + GRP_STRIDE * g;
  endfunction

  function automatic int unsigned grp_set_off(input int unsigned g);
    return grp_status_off(g) + SET_DELTA;
  endfunction

  function automatic int unsigned grp_clr_off(input int unsigned g);
    return grp_status_off(g) + CLR_DELTA;
  endfunction
endpackage

// File: rtl/sram_guard_size.sv
module sram_guard_size #(
  parameter int SIZE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [SIZE_W-1:0] size_q
);
  // Reset code: only the saturating top bit set, so the whole SRAM is secure.
  localparam logic [SIZE_W-1:0] SIZE_RST = {1'b1, {(SIZE_W-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     size_q <= SIZE_RST;
    else if (wr_en) size_q <= wdata[SIZE_W-1:0];
  end
endmodule

// File: rtl/sram_guard_grp.sv
module sram_guard_grp #(
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [GRP_W-1:0] mask,
  output logic [GRP_W-1:0] bits_q
);
  // Set and clear live at different addresses, so they never coincide.
  function automatic logic [GRP_W-1:0] apply_mask(
    input logic [GRP_W-1:0] cur, input logic [GRP_W-1:0] m,
    input logic do_set, input logic do_clr);
    logic [GRP_W-1:0] nxt;
    nxt = cur;
    if (do_set) nxt = nxt | m;
    if (do_clr) nxt = nxt & ~m;
    return nxt;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= apply_mask(bits_q, mask, set_en, clr_en);
  end
endmodule

// File: rtl/sram_guard_region.sv
module sram_guard_region #(
  parameter int SIZE_W     = 10,
  parameter int OFS_W      = 22,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [SIZE_W-1:0] size_q,
  input  logic [OFS_W-1:0]  offset,
  input  logic              ns,
  output logic              violation
);
  localparam int PG_W = OFS_W - PAGE_SHIFT;
  localparam int CW   = ((PG_W > SIZE_W) ? PG_W : SIZE_W) + 1;

  // Top size bit set means the whole memory is secure; otherwise
  // an access is inside the secure slice when its page is below the size.
  function automatic logic in_secure(input logic [SIZE_W-1:0] sz,
                                     input logic [PG_W-1:0]   page);
    if (sz[SIZE_W-1]) return 1'b1;
    return CW'(page) < CW'(sz);
  endfunction

  logic [PG_W-1:0] page;
  assign page      = offset[OFS_W-1:PAGE_SHIFT];
  assign violation = ns && in_secure(size_q, page);
endmodule

// File: rtl/sram_guard.sv
module sram_guard
  import sram_guard_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int GROUPS     = 3,
  parameter int GRP_W      = 8,
  parameter int SIZE_W     = 10,
  parameter int OFS_W      = 22,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    psel,
  input  logic                    penable,
  input  logic                    pwrite,
  input  logic                    pns,
  input  logic [ADDR_W-1:0]       paddr,
  input  logic [31:0]             pwdata,
  output logic [31:0]             prdata,
  output logic                    pready,
  output logic                    pslverr,
  output logic [GROUPS*GRP_W-1:0] ns_enable,
  input  logic [OFS_W-1:0]        chk_offset,
  input  logic                    chk_ns,
  output logic                    chk_violation
);
  localparam int NW = GROUPS * GRP_W;

  // Named access events, used by the bound checker.
  logic access, wr_fire, wr_blocked, size_wr, grp_wr_any;
  logic [SIZE_W-1:0] size_q;
  logic [GROUPS-1:0] set_hit, clr_hit;
  logic [GRP_W-1:0]  grp_bits [GROUPS];

  assign access     = psel && penable;
  assign wr_fire    = access && pwrite && !pns;
  assign wr_blocked = access && pwrite && pns;
  assign size_wr    = wr_fire && (paddr == ADDR_W'(SIZE_OFF));
  assign grp_wr_any = |(set_hit | clr_hit);

  assign pready  = 1'b1;
  assign pslverr = wr_blocked;

  sram_guard_size #(.SIZE_W(SIZE_W)) u_size (
    .clk(clk), .rst_n(rst_n), .wr_en(size_wr), .wdata(pwdata), .size_q(size_q)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign set_hit[g] = wr_fire && (paddr == ADDR_W'(grp_set_off(g)));
    assign clr_hit[g] = wr_fire && (paddr == ADDR_W'(grp_clr_off(g)));

    sram_guard_grp #(.GRP_W(GRP_W)) u_grp (
      .clk(clk), .rst_n(rst_n), .set_en(set_hit[g]), .clr_en(clr_hit[g]),
      .mask(pwdata[GRP_W-1:0]), .bits_q(grp_bits[g])
    );
    assign ns_enable[g*GRP_W +: GRP_W] = grp_bits[g];
  end

  // Read mux: status words and size; everything else returns zero.
  always_comb begin
    prdata = '0;
    if (paddr == ADDR_W'(SIZE_OFF)) prdata = 32'(size_q);
    for (int g = 0; g < GROUPS; g++) begin
      if (paddr == ADDR_W'(grp_status_off(g))) prdata = 32'(grp_bits[g]);
    end
  end

  sram_guard_region #(.SIZE_W(SIZE_W), .OFS_W(OFS_W), .PAGE_SHIFT(PAGE_SHIFT)) u_region (
    .size_q(size_q), .offset(chk_offset), .ns(chk_ns), .violation(chk_violation)
  );
endmodule

// File: rtl/sram_guard_sva.sv
module sram_guard_sva #(
  parameter int SIZE_W = 10,
  parameter int NW     = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              size_wr,
  input logic              wr_blocked,
  input logic              grp_wr_any,
  input logic [31:0]       pwdata,
  input logic [SIZE_W-1:0] size_q,
  input logic [NW-1:0]     ns_enable,
  input logic              chk_ns,
  input logic              chk_violation
);
  p_size_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    size_wr |=> size_q == $past(pwdata[SIZE_W-1:0]));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_wr_any |=> $stable(ns_enable));

  p_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> ($stable(ns_enable) && $stable(size_q)));

  p_zero_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q == '0) |-> !chk_violation);

  p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q[SIZE_W-1] && chk_ns) |-> chk_violation);

  p_secure_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_ns |-> !chk_violation);
endmodule

bind sram_guard sram_guard_sva #(.SIZE_W(SIZE_W), .NW(GROUPS*GRP_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .size_wr(size_wr), .wr_blocked(wr_blocked),
  .grp_wr_any(grp_wr_any), .pwdata(pwdata), .size_q(size_q),
  .ns_enable(ns_enable), .chk_ns(chk_ns), .chk_violation(chk_violation)
);

// File: tb/sram_guard_bench.sv
module sram_guard_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0, pns = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr, chk_violation;
  logic [23:0] ns_enable;
  logic [21:0] chk_offset = '0;
  logic chk_ns = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_guard u_sram_guard (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pns(pns), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .ns_enable(ns_enable), .chk_offset(chk_offset),
    .chk_ns(chk_ns), .chk_violation(chk_violation)
  );

  typedef struct packed {
    logic        rd;
    logic        ns;
    logic [11:0] addr;
    logic [31:0] data;   // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 12'h804, 32'h0000_00A5, 4'd2},  // R2 set group 0
    '{1'b1, 1'b0, 12'h800, 32'h0000_00A5, 4'd2},
    '{1'b0, 1'b0, 12'h808, 32'h0000_0081, 4'd3},  // R3 clear group 0
    '{1'b1, 1'b0, 12'h800, 32'h0000_0024, 4'd3},
    '{1'b0, 1'b0, 12'h810, 32'hFFFF_FF3C, 4'd2},  // R2 upper bits ignored
    '{1'b1, 1'b0, 12'h80C, 32'h0000_003C, 4'd2},
    '{1'b0, 1'b0, 12'h81C, 32'h0000_000F, 4'd2},
    '{1'b0, 1'b0, 12'h820, 32'h0000_0003, 4'd3},
    '{1'b1, 1'b0, 12'h818, 32'h0000_000C, 4'd3},
    '{1'b1, 1'b0, 12'h804, 32'h0000_0000, 4'd4},  // R4 set address reads zero
    '{1'b1, 1'b0, 12'h820, 32'h0000_0000, 4'd4},  // R4 clear address reads zero
    '{1'b0, 1'b0, 12'h000, 32'hFFFF_F403, 4'd1},  // R1 size masked to 10 bits
    '{1'b1, 1'b0, 12'h000, 32'h0000_0003, 4'd1},
    '{1'b0, 1'b0, 12'h810, 32'h0000_0000, 4'd2},  // R2 zero mask no effect
    '{1'b1, 1'b0, 12'h80C, 32'h0000_003C, 4'd2},
    '{1'b0, 1'b1, 12'h804, 32'h0000_00FF, 4'd10}, // R10 non-secure write dropped
    '{1'b1, 1'b0, 12'h800, 32'h0000_0024, 4'd10}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apb(input logic wr, input logic ns, input logic [11:0] a,
                     input logic [31:0] d, output logic [31:0] rd, output logic err);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; pns = ns; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    #1; rd = prdata; err = pslverr;
    check("R11 pready", 32'(pready), 32'd1);
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; pns = 0;
  endtask

  task automatic region(input logic [21:0] ofs, input logic ns, input logic exp, input string tag);
    @(negedge clk);
    chk_offset = ofs; chk_ns = ns;
    #1 check(tag, 32'(chk_violation), 32'(exp));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    logic err;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R5 reset state
    #1 check("R5 ns_enable after reset", 32'(ns_enable), 32'd0);
    apb(1'b0, 1'b0, 12'h000, 32'd0, rd, err);
    check("R5 size after reset", rd, 32'h200);
    apb(1'b0, 1'b0, 12'h818, 32'd0, rd, err);
    check("R5 group 2 after reset", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apb(!TBL[i].rd, TBL[i].ns, TBL[i].addr, TBL[i].rd ? 32'd0 : TBL[i].data, rd, err);
      if (TBL[i].rd) check($sformatf("R%0d table row %0d", TBL[i].req, i), rd, TBL[i].data);
    end

    // R6 output mapping
    #1 check("R6 ns_enable mapping", 32'(ns_enable), 32'h000C_3C24);

    // R6 timing: bit 3 of group 0 rises only after the access phase edge
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = 12'h804; pwdata = 32'h08;
    @(negedge clk);
    penable = 1;
    #1 check("R6 before edge", 32'(ns_enable[3]), 32'd0);
    @(negedge clk);
    check("R6 after edge", 32'(ns_enable[3]), 32'd1);
    psel = 0; penable = 0; pwrite = 0;

    // R10 error response
    apb(1'b1, 1'b1, 12'h000, 32'h001, rd, err);
    check("R10 ns write error", 32'(err), 32'd1);
    apb(1'b0, 1'b1, 12'h000, 32'd0, rd, err);
    check("R10 ns read no error", 32'(err), 32'd0);
    check("R10 ns size write dropped", rd, 32'h003);
    apb(1'b1, 1'b0, 12'h814, 32'h0000_0004, rd, err);
    check("R10 secure write no error", 32'(err), 32'd0);

    // R7 region edges, size 3
    region(22'h002FFF, 1'b1, 1'b1, "R7 last secure byte");
    region(22'h003000, 1'b1, 1'b0, "R7 first open byte");
    region(22'h000000, 1'b0, 1'b0, "R9 secure access inside");
    apb(1'b1, 1'b0, 12'h000, 32'h000, rd, err);
    region(22'h000000, 1'b1, 1'b0, "R7 size zero");
    apb(1'b1, 1'b0, 12'h000, 32'h1FF, rd, err);
    region(22'h1FEFFF, 1'b1, 1'b1, "R7 size 1FF inside");
    region(22'h1FF000, 1'b1, 1'b0, "R7 size 1FF edge");
    apb(1'b1, 1'b0, 12'h000, 32'h200, rd, err);
    region(22'h3FFFFF, 1'b1, 1'b1, "R8 size 200 top byte");
    region(22'h3FFFFF, 1'b0, 1'b0, "R9 secure under saturation");
    apb(1'b1, 1'b0, 12'h000, 32'h3FF, rd, err);
    region(22'h200000, 1'b1, 1'b1, "R8 size 3FF");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule